// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement Unit

This unit holds the replacement-choice state for a four-way set-associative cache with a configurable number of sets. Each set has three bits arranged as a binary tree. The four ways sit at its leaves. The unit sees every cache hit and every line fill for a set and the way it touched. It then rewrites that set's tree so the tree points away from the touched way. The tag store, the data store and hit detection all live outside the unit.

When the cache misses, the surrounding logic presents a set index and that set's four valid bits. The unit then names the way to evict. An empty way always wins, and the lowest-numbered empty way is taken first. When all four ways are valid, the unit walks the tree from the root to a leaf. The victim answer is combinational. A touch changes the tree only at the next rising clock edge. A synchronous reset returns every set's tree to its starting value.

Top module: `tree_plru_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every set's tree is cleared to all zeros. After that, a set with all four ways valid and no touch since reset reports victim way 0.
- R2: If `lookupValid` (bit i is way i) is not 4'b1111, the victim is the lowest-numbered way whose valid bit is 0. The tree bits are not used in this case.
- R3: If all four ways are valid, the victim comes from the tree bits of the looked-up set. When the root bit is 0, the left-pair bit picks the way: 0 gives way 0 and 1 gives way 1. When the root bit is 1, the right-pair bit picks the way: 0 gives way 2 and 1 gives way 3.
- R4: A touch to way 0 or way 1 sets the root to 1. It sets the left-pair bit to the sibling: 1 after a touch to way 0, and 0 after a touch to way 1. The right-pair bit keeps its value.
- R5: A touch to way 2 or way 3 sets the root to 0. It sets the right-pair bit to the sibling: 1 after a touch to way 2, and 0 after a touch to way 3. The left-pair bit keeps its value.
- R6: `victimWay` follows `lookupSet` and `lookupValid` combinationally. A touch presented in a cycle changes the reported victim only after the next rising edge.
- R7: A touch changes only the tree of the set named by `touchSet`. The victims of all other sets stay the same.
- R8: While `touchEn` is low, the values on `touchSet` and `touchWay` have no effect on any tree.
- R9: With all four ways valid, a set's victim in the cycle after a touch is never the way that was just touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| touchEn | input | 1 | Strobe: a hit or fill happened in this cycle |
| touchSet | input | SET_W | Set index of the hit or fill |
| touchWay | input | 2 | Way that was hit or filled |
| lookupSet | input | SET_W | Set index for the victim query |
| lookupValid | input | 4 | Valid bits of the queried set, bit i for way i |
| victimWay | output | 2 | Way chosen for replacement |

## Verification
The bench goes after the sibling rule in both halves of the tree. A design that pointed a leaf bit at the touched way would evict the line it just used, and a design that also rewrote the off-path pair bit would lose older history, so the victim would drift from the model after a later touch. It checks that an invalid way takes priority over the tree, lowest index first. This catches a design that skipped that priority or scanned the ways from the top. It probes a set in the very cycle it is touched, which exposes a design whose update reached the victim output too early. It also touches one set and probes the others, and it drives stray set and way values while the strobe is low. These two probes catch write decoding that leaks into the wrong set or that ignores the enable.

// File: rtl/tree_plru_pkg.sv
package tree_plru_pkg;
  localparam int WAYS   = 4;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TREE_W = WAYS - 1;
  // positions of the tree bits: root, left pair (ways 0/1), right pair (ways 2/3)
  localparam int ROOT  = 0;
  localparam int LEFT  = 1;
  localparam int RIGHT = 2;

  typedef logic [TREE_W-1:0] treeBits_t;

  typedef struct packed {
    logic      wrEn;
    treeBits_t wrMask;
    treeBits_t wrVal;
  } treeStrobe_t;
endpackage

// File: rtl/tree_plru_ctrl.sv
module tree_plru_ctrl
  import tree_plru_pkg::*;
(
  input  logic             touchEn,
  input  logic [WAY_W-1:0] touchWay,
  input  treeBits_t        rdBits,
  input  logic [WAYS-1:0]  lookupValid,
  output treeStrobe_t      strobe,
  output logic [WAY_W-1:0] victimWay
);
  logic anyFree;
  logic [WAY_W-1:0] freeWay;
  logic [WAY_W-1:0] treeWay;

  // update encoding: the touched half's pair bit points at the sibling
  always_comb begin
    strobe        = '0;
    strobe.wrEn   = touchEn;
    if (!touchWay[1]) begin
      strobe.wrMask[ROOT] = 1'b1;
      strobe.wrMask[LEFT] = 1'b1;
      strobe.wrVal[ROOT]  = 1'b1;
      strobe.wrVal[LEFT]  = ~touchWay[0];
    end else begin
      strobe.wrMask[ROOT]  = 1'b1;
      strobe.wrMask[RIGHT] = 1'b1;
      strobe.wrVal[ROOT]   = 1'b0;
      strobe.wrVal[RIGHT]  = ~touchWay[0];
    end
  end

  // lowest-numbered invalid way
  always_comb begin
    anyFree = 1'b0;
    freeWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!lookupValid[w]) begin
        anyFree = 1'b1;
        freeWay = WAY_W'(w);
      end
    end
  end

  // tree walk
  always_comb begin
    if (rdBits[ROOT]) treeWay = {1'b1, rdBits[RIGHT]};
    else              treeWay = {1'b0, rdBits[LEFT]};
  end

  assign victimWay = anyFree ? freeWay : treeWay;
endmodule

// File: rtl/tree_plru_store.sv
module tree_plru_store
  import tree_plru_pkg::*;
#(
  parameter int SETS = 16,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  treeStrobe_t      strobe,
  input  logic [SET_W-1:0] wrSet,
  input  logic [SET_W-1:0] rdSet,
  output treeBits_t        rdBits
);
  treeBits_t stateArr [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (rst) begin
        stateArr[s] <= '0;
      end else if (strobe.wrEn && (wrSet == SET_W'(s))) begin
        stateArr[s] <= (stateArr[s] & ~strobe.wrMask) | (strobe.wrVal & strobe.wrMask);
      end
    end
  end

  always_comb begin
    rdBits = '0;
    for (int s = 0; s < SETS; s++) begin
      if (rdSet == SET_W'(s)) rdBits = stateArr[s];
    end
  end
endmodule

// File: rtl/tree_plru_unit.sv
module tree_plru_unit
  import tree_plru_pkg::*;
#(
  parameter int SETS = 16,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touchEn,
  input  logic [SET_W-1:0] touchSet,
  input  logic [1:0]       touchWay,
  input  logic [SET_W-1:0] lookupSet,
  input  logic [3:0]       lookupValid,
  output logic [1:0]       victimWay
);
  treeStrobe_t strobe;
  treeBits_t   rdBits;

  tree_plru_ctrl u_ctrl (
    .touchEn     (touchEn),
    .touchWay    (touchWay),
    .rdBits      (rdBits),
    .lookupValid (lookupValid),
    .strobe      (strobe),
    .victimWay   (victimWay)
  );

  tree_plru_store #(.SETS(SETS)) u_store (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .wrSet  (touchSet),
    .rdSet  (lookupSet),
    .rdBits (rdBits)
  );
endmodule

// File: rtl/tree_plru_chk.sv
module tree_plru_chk #(
  parameter int SETS = 16,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             touchEn,
  input logic [SET_W-1:0] touchSet,
  input logic [1:0]       touchWay,
  input logic [SET_W-1:0] lookupSet,
  input logic [3:0]       lookupValid,
  input logic [1:0]       victimWay
);
  logic [3:0] lowMask;
  always_comb lowMask = (4'b0001 << victimWay) - 4'b0001;

  // R1: right after reset a full set evicts way 0
  p_reset_way0_r1: assert property (@(posedge clk)
    ($past(rst) && !rst && lookupValid == 4'hF) |-> victimWay == 2'd0);

  // R2: a free way wins, lowest index first
  p_invalid_first_r2: assert property (@(posedge clk) disable iff (rst)
    (lookupValid != 4'hF) |-> (!lookupValid[victimWay] && ((lookupValid & lowMask) == lowMask)));

  // R9: the way just touched is not evicted next
  p_not_recent_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(touchEn) && !$past(rst) && lookupSet == $past(touchSet) && lookupValid == 4'hF)
      |-> victimWay != $past(touchWay));

  // R8: no strobe, same query, same answer
  p_idle_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(touchEn) && !$past(rst) && $stable(lookupSet) && $stable(lookupValid))
      |-> $stable(victimWay));

  // R7: a touch elsewhere leaves this set alone
  p_other_set_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(touchEn) && !$past(rst) && $past(touchSet) != lookupSet
     && $stable(lookupSet) && $stable(lookupValid)) |-> $stable(victimWay));
endmodule

bind tree_plru_unit tree_plru_chk #(.SETS(SETS)) u_chk (.*);

// File: tb/tb_tree_plru_unit.sv
`timescale 1ns/1ps
module tb_tree_plru_unit;
  localparam int SETS  = 16;
  localparam int SET_W = $clog2(SETS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic touchEn = 1'b0;
  logic [SET_W-1:0] touchSet = '0;
  logic [1:0] touchWay = '0;
  logic [SET_W-1:0] lookupSet = '0;
  logic [3:0] lookupValid = 4'hF;
  logic [1:0] victimWay;

  always #2.5 clk = ~clk;

  tree_plru_unit #(.SETS(SETS)) dut (
    .clk(clk), .rst(rst), .touchEn(touchEn), .touchSet(touchSet),
    .touchWay(touchWay), .lookupSet(lookupSet), .lookupValid(lookupValid),
    .victimWay(victimWay)
  );

  typedef struct { logic [1:0] exp; string tag; } item_t;
  item_t sbq[$];
  event probeEv;
  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [2:0] mdl [SETS]; // [0] root, [1] left pair, [2] right pair

  function automatic logic [1:0] expVictim(logic [2:0] t, logic [3:0] v);
    if (v != 4'hF) begin
      for (int w = 0; w < 4; w++) if (!v[w]) return 2'(w);
    end
    return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction

  task automatic mdlTouch(int s, logic [1:0] w);
    if (!w[1]) begin mdl[s][0] = 1'b1; mdl[s][1] = ~w[0]; end
    else       begin mdl[s][0] = 1'b0; mdl[s][2] = ~w[0]; end
  endtask

  // monitor: pops and compares
  initial forever begin
    item_t it;
    @(probeEv);
    #1;
    it = sbq.pop_front();
    checks++;
    if (victimWay !== it.exp) begin
      fails++;
      $display("FAIL %s: victimWay=%0d expected=%0d", it.tag, victimWay, it.exp);
    end
  end

  task automatic push(logic [1:0] e, string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sbq.push_back(it);
    -> probeEv;
    #1.5;
  endtask

  task automatic probe(int s, logic [3:0] v, string tag);
    @(negedge clk);
    lookupSet = SET_W'(s);
    lookupValid = v;
    push(expVictim(mdl[s], v), tag);
  endtask

  // touch with a same-cycle probe (old value) and a next-cycle probe (new value)
  task automatic touch(int s, logic [1:0] w, string tag);
    @(negedge clk);
    touchEn = 1'b1; touchSet = SET_W'(s); touchWay = w;
    lookupSet = SET_W'(s); lookupValid = 4'hF;
    push(expVictim(mdl[s], 4'hF), "R6 same-cycle");
    @(posedge clk);
    mdlTouch(s, w);
    #1 touchEn = 1'b0;
    push(expVictim(mdl[s], 4'hF), tag);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    for (int s = 0; s < SETS; s++) mdl[s] = 3'b000;
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    doReset();
    for (int s = 0; s < SETS; s++) probe(s, 4'hF, "R1 reset");

    // R4 / R5 sibling rules, set 3
    touch(3, 2'd0, "R4 touch way0");
    touch(3, 2'd2, "R5 touch way2");
    touch(3, 2'd1, "R4 touch way1");
    touch(3, 2'd3, "R5 touch way3");
    touch(3, 2'd2, "R5 keeps left");
    touch(3, 2'd1, "R4 keeps right");
    probe(3, 4'hF, "R3 walk");

    // R2 free-way priority against a non-zero tree
    probe(3, 4'b1110, "R2 free way0");
    probe(3, 4'b1101, "R2 free way1");
    probe(3, 4'b1011, "R2 free way2");
    probe(3, 4'b0111, "R2 free way3");
    probe(3, 4'b0101, "R2 lowest of two");
    probe(3, 4'b0000, "R2 all free");

    // R7 other sets untouched
    touch(5, 2'd0, "R7 set5 touch");
    touch(5, 2'd3, "R7 set5 touch");
    probe(3, 4'hF, "R7 set3 unchanged");
    probe(4, 4'hF, "R7 set4 unchanged");
    probe(6, 4'hF, "R7 set6 unchanged");

    // R8 stray inputs without strobe
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      touchEn = 1'b0; touchSet = SET_W'(k % 2 ? 3 : 5); touchWay = 2'(k);
    end
    probe(3, 4'hF, "R8 no strobe set3");
    probe(5, 4'hF, "R8 no strobe set5");

    // R3 mixed sweep against the model
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      touch(int'(lfsr[3:0]), lfsr[5:4], "R3 sweep");
      if (lfsr[6]) probe(int'(lfsr[10:7]), lfsr[14:11], "R3 sweep probe");
    end

    // R1 reset mid-run
    doReset();
    for (int s = 0; s < SETS; s++) probe(s, 4'hF, "R1 re-reset");

    @(negedge clk); @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule